// File: doc/BRIEF.md
# Byte-Streaming Network Device Register Interface

This block is the device half of a minimal memory-mapped network adapter. A processor reaches it through a 32-bit register bus with a byte address, single-cycle read and write strobes and word data. Frames travel one byte per register access. On receive, a frame streamed in from the network side is stored in an internal buffer and a readable count shows how many bytes remain. The processor pops the bytes one by one from a data port. On transmit, the processor writes a length and then that many bytes to a second data port. Each byte leaves on the outgoing byte port in the cycle after the write.

Three pending conditions drive a single interrupt line: transmit complete, receive data available and a software test interrupt. The two event flags are cleared by writing 1 to them. The test flag has split behaviour: its readable bit is cleared by reading the control word, while the interrupt it raised stays pending until the control word is written with all zeros. Frames that cannot be taken are discarded and counted. A frame is discarded when it arrives while received data is still flagged, or when it is longer than the buffer.

Top module: `bytenet_regs`

## Requirements
- R1: Word reads return the device identifier (default ASCII "BYTENET0", first character in the least significant byte) with the low half at 0x00 and the high half at 0x04, and return the routing constant (default 3) at 0x18. Out of reset the counts at 0x0C, 0x10 and 0x24 read 0, the busy word at 0x08 reads 0 and irq is low.
- R2: Bit 0 of the busy word at 0x08 reads 1 from the cycle after a frame start is taken until its last byte has been taken. It also reads 1 while a transmit length is pending. Otherwise it reads 0.
- R3: A frame start (rx_sof, rx_len not 0) that is taken is followed by rx_len strobes of rx_byte_vld. The clock edge that takes the last byte loads the receive count at 0x0C with the length and sets bit 1 of the interrupt control word at 0x14.
- R4: Each read strobe at 0x1C returns the next stored byte in arrival order in bits 7:0, with bits 31:8 zero, and decrements the receive count. When the count is 0, such a read returns 0 and leaves the count at 0.
- R5: A frame that starts while bit 1 at 0x14 is set, or whose length exceeds the buffer depth (default 2048), is dropped. The drop counter at 0x24 rises by one, and the receive count and the stored bytes stay unchanged. A frame exactly as long as the buffer is accepted.
- R6: A write at 0x10 of a length from 1 to 65536 while no length is pending is stored. Each following write at 0x20 puts its bits 7:0 on tx_byte with tx_valid high for one cycle after the write edge. tx_last is high with the byte that completes the length. That same write clears 0x10 to 0 and sets bit 0 at 0x14.
- R7: Writes at 0x20 while 0x10 reads 0 produce no output byte. Writes at 0x10 of 0, of a value above 65536, or made while a length is pending leave 0x10 unchanged.
- R8: Writing a 1 to bit 0 or bit 1 at 0x14 clears that flag. Writing 0 to those bits leaves them set.
- R9: Writing a word with bit 31 set at 0x14 sets bit 31 and raises the test interrupt. A read strobe at 0x14 clears bit 31 but keeps the test interrupt pending. A write of all zeros at 0x14 clears the test interrupt.
- R10: irq is high exactly when the transmit-done flag, the receive-available flag or the test interrupt is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 6 | Byte address of the register access, word aligned |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| rx_sof | input | 1 | Frame start from the network side, qualifies rx_len |
| rx_len | input | 17 | Byte length of the starting frame |
| rx_byte_vld | input | 1 | A received byte is present on rx_byte |
| rx_byte | input | 8 | Received byte |
| tx_valid | output | 1 | Outgoing byte present on tx_byte |
| tx_byte | output | 8 | Outgoing byte |
| tx_last | output | 1 | Marks the final byte of an outgoing frame |
| irq | output | 1 | Interrupt request, level |

## Verification
Read data is combinational, so a register's value can be sampled on the bus in the same cycle as the access, before the read side effect takes place. Effects of a strobe appear on the ports one clock edge later: a popped byte, a changed count, a cleared flag, or tx_valid with its byte. The bench drives every stimulus on the falling edge and samples at the next falling edge, one full cycle on. Outgoing bytes are predicted by the write task, queued, and compared by a monitor that pops one entry for every tx_valid cycle it sees. An output byte that nothing predicted is reported, and so is a prediction left in the queue at the end.

// File: rtl/bytenet_regs.sv
`timescale 1ns/1ps
module bytenet_regs #(
  parameter int BUF_DEPTH = 2048,
  parameter int CNT_W = 17,
  parameter int MAX_LEN = 65536,
  parameter logic [63:0] DEV_ID = 64'h3054454E_45545942,
  parameter logic [31:0] IRQ_INFO = 32'h0000_0003
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [5:0]       bus_addr,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic             rx_sof,
  input  logic [CNT_W-1:0] rx_len,
  input  logic             rx_byte_vld,
  input  logic [7:0]       rx_byte,
  output logic             tx_valid,
  output logic [7:0]       tx_byte,
  output logic             tx_last,
  output logic             irq
);
  localparam int PTR_W = $clog2(BUF_DEPTH);

  logic [7:0]       mem [BUF_DEPTH];
  logic             rx_active, rx_drop, rx_flag, tx_flag, test_bit, test_irq;
  logic [CNT_W-1:0] rx_left, rx_flen, rx_count, tx_count, tx_sent;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [31:0]      drop_cnt;

  wire       aligned  = bus_addr[1:0] == 2'b00;
  wire [3:0] wa       = bus_addr[5:2];
  wire       ctl_wr   = bus_wr && aligned && wa == 4'd5;
  wire       ctl_rd   = bus_rd && aligned && wa == 4'd5;
  wire       pop      = bus_rd && aligned && wa == 4'd7 && rx_count != '0;
  wire       len_wr   = bus_wr && aligned && wa == 4'd4 && tx_count == '0 &&
                        bus_wdata != 32'd0 && bus_wdata <= 32'(MAX_LEN);
  wire       dat_wr   = bus_wr && aligned && wa == 4'd8 && tx_count != '0;
  wire       tx_end   = dat_wr && (tx_sent + 1'b1 == tx_count);
  wire       start_ok = rx_sof && !rx_active && rx_len != '0;
  wire       take     = rx_active && rx_byte_vld;
  wire       rx_done  = take && rx_left == CNT_W'(1) && !rx_drop;
  wire       busy     = rx_active || tx_count != '0;

  always_ff @(posedge clk) begin
    if (take && !rx_drop) mem[wr_ptr] <= rx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_active <= 1'b0;
      rx_drop   <= 1'b0;
      rx_left   <= '0;
      rx_flen   <= '0;
      wr_ptr    <= '0;
      drop_cnt  <= '0;
    end else if (start_ok) begin
      rx_active <= 1'b1;
      rx_left   <= rx_len;
      rx_flen   <= rx_len;
      wr_ptr    <= '0;
      rx_drop   <= rx_flag || rx_len > CNT_W'(BUF_DEPTH);
      if (rx_flag || rx_len > CNT_W'(BUF_DEPTH)) drop_cnt <= drop_cnt + 32'd1;
    end else if (take) begin
      wr_ptr  <= wr_ptr + 1'b1;
      rx_left <= rx_left - 1'b1;
      if (rx_left == CNT_W'(1)) rx_active <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_count <= '0;
      rd_ptr   <= '0;
    end else if (rx_done) begin
      rx_count <= rx_flen;
      rd_ptr   <= '0;
    end else if (pop) begin
      rx_count <= rx_count - 1'b1;
      rd_ptr   <= rd_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_count <= '0;
      tx_sent  <= '0;
      tx_valid <= 1'b0;
      tx_byte  <= 8'd0;
      tx_last  <= 1'b0;
    end else begin
      tx_valid <= dat_wr;
      tx_last  <= tx_end;
      if (dat_wr) tx_byte <= bus_wdata[7:0];
      if (len_wr) begin
        tx_count <= bus_wdata[CNT_W-1:0];
        tx_sent  <= '0;
      end else if (tx_end) begin
        tx_count <= '0;
        tx_sent  <= '0;
      end else if (dat_wr) begin
        tx_sent <= tx_sent + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_flag  <= 1'b0;
      tx_flag  <= 1'b0;
      test_bit <= 1'b0;
      test_irq <= 1'b0;
    end else begin
      if (rx_done) rx_flag <= 1'b1;
      else if (ctl_wr && bus_wdata[1]) rx_flag <= 1'b0;
      if (tx_end) tx_flag <= 1'b1;
      else if (ctl_wr && bus_wdata[0]) tx_flag <= 1'b0;
      if (ctl_wr && bus_wdata[31]) begin
        test_bit <= 1'b1;
        test_irq <= 1'b1;
      end else if (ctl_wr && bus_wdata == 32'd0) begin
        test_irq <= 1'b0;
      end else if (ctl_rd) begin
        test_bit <= 1'b0;
      end
    end
  end

  always_comb begin
    bus_rdata = 32'd0;
    if (aligned) begin
      case (wa)
        4'd0: bus_rdata = DEV_ID[31:0];
        4'd1: bus_rdata = DEV_ID[63:32];
        4'd2: bus_rdata = {31'd0, busy};
        4'd3: bus_rdata = 32'(rx_count);
        4'd4: bus_rdata = 32'(tx_count);
        4'd5: bus_rdata = {test_bit, 29'd0, rx_flag, tx_flag};
        4'd6: bus_rdata = IRQ_INFO;
        4'd7: bus_rdata = (rx_count != '0) ? {24'd0, mem[rd_ptr]} : 32'd0;
        4'd9: bus_rdata = drop_cnt;
        default: bus_rdata = 32'd0;
      endcase
    end
  end

  assign irq = tx_flag | rx_flag | test_irq;
endmodule

// File: rtl/bytenet_regs_chk.sv
`timescale 1ns/1ps
module bytenet_regs_chk #(
  parameter int CNT_W = 17
) (
  input logic             clk,
  input logic             rst_n,
  input logic [5:0]       bus_addr,
  input logic             bus_rd,
  input logic             bus_wr,
  input logic [31:0]      bus_wdata,
  input logic             rx_sof,
  input logic [CNT_W-1:0] rx_len,
  input logic             rx_active,
  input logic             rx_flag,
  input logic [CNT_W-1:0] rx_count,
  input logic             test_irq,
  input logic [31:0]      drop_cnt,
  input logic             tx_valid
);
  wire is_ctl_wr = bus_wr && bus_addr == 6'h14;

  a_r6_tx_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(bus_wr && bus_addr == 6'h20));

  a_r4_pop_decrements: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 6'h1C && rx_count != '0 && rx_flag && !is_ctl_wr)
    |=> (rx_count + 1'b1 == $past(rx_count)));

  a_r4_empty_read_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 6'h1C && rx_count == '0 && !rx_active)
    |=> rx_count == '0);

  a_r5_drop_counted: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_sof && !rx_active && rx_flag && rx_len != '0)
    |=> drop_cnt == $past(drop_cnt) + 32'd1);

  a_r9_test_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ctl_wr && bus_wdata[31]) |=> test_irq);

  a_r9_test_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ctl_wr && bus_wdata == 32'd0) |=> !test_irq);
endmodule

bind bytenet_regs bytenet_regs_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/bytenet_regs_test.sv
`timescale 1ns/1ps
module bytenet_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rx_sof = 1'b0, rx_byte_vld = 1'b0;
  logic [16:0] rx_len = '0;
  logic [7:0]  rx_byte = '0;
  logic        tx_valid, tx_last, irq;
  logic [7:0]  tx_byte;

  int n_tests = 0, n_fail = 0;
  logic [8:0] exp_q[$];

  always #2.5 clk = ~clk;

  bytenet_regs uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic peek(input logic [5:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, input logic last);
    exp_q.push_back({last, b});
    wr(6'h20, {24'hABCDEF, b});
  endtask

  task automatic send_frame(input int len, input logic [7:0] base, input bit check_busy);
    logic [31:0] d;
    @(negedge clk);
    rx_sof = 1'b1; rx_len = 17'(len);
    @(negedge clk);
    rx_sof = 1'b0;
    if (check_busy) begin
      peek(6'h08, d);
      chk("R2 busy during receive", d, 32'd1);
    end
    for (int i = 0; i < len; i++) begin
      rx_byte_vld = 1'b1; rx_byte = 8'(base + i);
      @(negedge clk);
    end
    rx_byte_vld = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && tx_valid) begin
      n_tests++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R7 unexpected output byte: actual %h expected none", tx_byte);
      end else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        if ({tx_last, tx_byte} !== e) begin
          n_fail++;
          $display("FAIL R6 output byte: actual %h expected %h", {tx_last, tx_byte}, e);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    peek(6'h00, d); chk("R1 id low", d, 32'h45545942);
    peek(6'h04, d); chk("R1 id high", d, 32'h3054454E);
    peek(6'h18, d); chk("R1 routing", d, 32'd3);
    peek(6'h08, d); chk("R1 busy reset", d, 32'd0);
    peek(6'h0C, d); chk("R1 rx count reset", d, 32'd0);
    peek(6'h24, d); chk("R1 drops reset", d, 32'd0);
    chk("R1 R10 irq reset", 32'(irq), 32'd0);

    send_frame(5, 8'h10, 1'b1);
    peek(6'h0C, d); chk("R3 rx count loaded", d, 32'd5);
    peek(6'h14, d); chk("R3 rx flag set", d, 32'h2);
    peek(6'h08, d); chk("R2 busy clear after frame", d, 32'd0);
    chk("R10 irq from rx", 32'(irq), 32'd1);

    send_frame(3, 8'h80, 1'b0);
    peek(6'h24, d); chk("R5 drop while flagged", d, 32'd1);
    peek(6'h0C, d); chk("R5 count kept", d, 32'd5);

    for (int i = 0; i < 5; i++) begin
      rd(6'h1C, d); chk("R4 rx byte order", d, 32'(8'h10 + i));
      peek(6'h0C, d); chk("R4 rx count decrement", d, 32'(4 - i));
    end
    rd(6'h1C, d); chk("R4 empty read", d, 32'd0);
    peek(6'h0C, d); chk("R4 empty count held", d, 32'd0);

    wr(6'h14, 32'h0);
    peek(6'h14, d); chk("R8 zero write keeps flag", d, 32'h2);
    wr(6'h14, 32'h2);
    peek(6'h14, d); chk("R8 rx flag cleared", d, 32'h0);
    chk("R10 irq idle", 32'(irq), 32'd0);

    send_frame(2049, 8'h00, 1'b0);
    peek(6'h24, d); chk("R5 oversize dropped", d, 32'd2);
    peek(6'h0C, d); chk("R5 oversize no count", d, 32'd0);

    send_frame(2048, 8'h33, 1'b0);
    peek(6'h0C, d); chk("R5 full-depth accepted", d, 32'd2048);
    bad = 0;
    for (int i = 0; i < 2048; i++) begin
      rd(6'h1C, d);
      if (d !== 32'(8'(8'h33 + i))) bad++;
    end
    chk("R4 full-depth bytes", 32'(bad), 32'd0);
    wr(6'h14, 32'h2);

    wr(6'h20, 32'h55);
    peek(6'h10, d); chk("R7 stray data write", d, 32'd0);
    wr(6'h10, 32'd0);
    peek(6'h10, d); chk("R7 zero length ignored", d, 32'd0);
    wr(6'h10, 32'd65537);
    peek(6'h10, d); chk("R7 oversize length ignored", d, 32'd0);

    wr(6'h10, 32'd4);
    peek(6'h10, d); chk("R6 tx count stored", d, 32'd4);
    peek(6'h08, d); chk("R2 busy during transmit", d, 32'd1);
    wr(6'h10, 32'd9);
    peek(6'h10, d); chk("R7 pending length kept", d, 32'd4);
    send_byte(8'hA1, 1'b0);
    send_byte(8'hB2, 1'b0);
    send_byte(8'hC3, 1'b0);
    peek(6'h14, d); chk("R6 no done before last", d, 32'h0);
    send_byte(8'hD4, 1'b1);
    peek(6'h10, d); chk("R6 tx count cleared", d, 32'd0);
    peek(6'h14, d); chk("R6 tx done flag", d, 32'h1);
    chk("R10 irq from tx", 32'(irq), 32'd1);
    wr(6'h14, 32'h1);
    peek(6'h14, d); chk("R8 tx flag cleared", d, 32'h0);

    wr(6'h14, 32'h8000_0000);
    chk("R9 test irq raised", 32'(irq), 32'd1);
    rd(6'h14, d); chk("R9 test bit visible", d, 32'h8000_0000);
    rd(6'h14, d); chk("R9 test bit cleared by read", d, 32'h0);
    chk("R9 irq still pending", 32'(irq), 32'd1);
    wr(6'h14, 32'h0);
    chk("R9 R10 irq cleared by zero write", 32'(irq), 32'd0);

    wr(6'h10, 32'd65536);
    peek(6'h10, d); chk("R6 max length accepted", d, 32'd65536);

    repeat (3) @(negedge clk);
    chk("R6 all bytes seen", 32'(exp_q.size()), 32'd0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule